// File: doc/BRIEF.md
# Restart Region Exception Controller

This block sits beside the commit stage of a core that runs vector code. It follows a stream of retiring instructions. Each retiring instruction carries its PC and two marker flags: one opens an idempotent restart region and one closes it. While a region is open, the block holds one head address, which is the instruction just after the opening marker. Instructions inside the region may complete in any order. The block keeps no per-instruction result buffer.

A fault such as a page fault reaches the block on its own port. The block then emits a single-cycle flush together with a redirect PC. Inside a region, fetch restarts at the stored head, so the whole region is re-executed. Outside a region, the redirect PC is the faulting instruction's own PC, which gives precise behaviour. With the flush, the block tells the context-save logic which register classes to keep. Inside a region, vector registers count as scratch state and are not saved. The block then stays frozen and ignores commit traffic until the handler sends a resume strobe.

Top module: `restart_region_ctrl`

## Requirements
- R1: After reset the region flag is 0, the head register is 0, `flush_o` is 0 and `halted_o` is 0.
- R2: An accepted retire with `ret_begin` set opens the region and loads the head with the retire PC plus INSTR_BYTES, modulo 2^PC_W. The new value is visible on the next cycle.
- R3: A begin marker that retires while a region is already open overwrites the head. Regions do not nest.
- R4: An accepted retire with `ret_end` set (and `ret_begin` clear) closes the region and leaves the head unchanged. If both flags are set, the begin takes effect.
- R5: A fault taken while a region is open produces a redirect to the stored head. `save_mask_o` is then 3'b011: bit 0 is scalar registers, bit 1 is the head register, bit 2 is vector registers.
- R6: A fault taken with no region open produces a redirect to `fault_pc`, with `save_mask_o` equal to 3'b101.
- R7: A taken fault raises `flush_o` for exactly one cycle, on the cycle after `fault_valid`. `redirect_pc_o` and `save_mask_o` are valid in that same cycle.
- R8: From the cycle after a taken fault until a `resume` strobe, `halted_o` is 1 and the block ignores retires and further faults. `resume` clears `halted_o` on the next cycle and has no effect while not halted.
- R9: When a fault arrives in the same cycle as a retire, the fault wins and the retire is discarded. A begin marker therefore leaves the head and flag untouched, and an end marker leaves the region open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | PC_W | PC of the retiring instruction |
| ret_begin | input | 1 | Retiring instruction is a region-open marker |
| ret_end | input | 1 | Retiring instruction is a region-close marker |
| fault_valid | input | 1 | An exception is reported this cycle |
| fault_pc | input | PC_W | PC of the faulting instruction |
| resume | input | 1 | Handler finished; restart commit tracking |
| flush_o | output | 1 | One-cycle pipeline flush pulse |
| redirect_pc_o | output | PC_W | Fetch restart address, valid with `flush_o` |
| save_mask_o | output | 3 | Register classes to preserve, valid with `flush_o` |
| halted_o | output | 1 | Waiting for the handler's resume strobe |
| region_open_o | output | 1 | A restart region is open |
| head_pc_o | output | PC_W | Stored region head address |

## Verification
The bench builds the block with PC_W = 16 and INSTR_BYTES = 2. A 16-bit PC lets a begin marker at 16'hFFFE push the head past the top of the address space, so the modulo wrap of R2 can be checked, and a redirect to address zero is exercised. The small instruction step also keeps the head distinct from the marker PC by an amount other than the default, so a hard-coded offset would be detected. The bench drives same-cycle collisions of a fault with begin and end markers, faults and retires during the frozen window, and resume strobes while not halted.

// File: rtl/rrx_pkg.sv
package rrx_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } ctl_state_e;

  localparam int SAVE_W    = 3;
  localparam int SV_SCALAR = 0;
  localparam int SV_HEAD   = 1;
  localparam int SV_VECTOR = 2;

  // Register classes to preserve when a fault is taken.
  function automatic logic [SAVE_W-1:0] save_classes(input logic in_region);
    logic [SAVE_W-1:0] m;
    m = '0;
    m[SV_SCALAR] = 1'b1;
    if (in_region) begin
      m[SV_HEAD] = 1'b1;   // region head must survive
    end else begin
      m[SV_VECTOR] = 1'b1; // precise mode keeps vector contents
    end
    return m;
  endfunction

endpackage

// File: rtl/rrx_region_track.sv
module rrx_region_track #(
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            is_begin,
  input  logic            is_end,
  input  logic [PC_W-1:0] pc,
  output logic            open_o,
  output logic [PC_W-1:0] head_o
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  logic            open_q, open_d;
  logic [PC_W-1:0] head_q, head_d;
  logic            head_en;

  always_comb begin
    open_d  = open_q;
    head_d  = head_q;
    head_en = 1'b0;
    if (accept) begin
      if (is_begin) begin
        open_d  = 1'b1;
        head_d  = pc + STEP;
        head_en = 1'b1;
      end else if (is_end) begin
        open_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      head_q <= '0;
    end else begin
      open_q <= open_d;
      if (head_en) begin
        head_q <= head_d;
      end
    end
  end

  assign open_o = open_q;
  assign head_o = head_q;

endmodule

// File: rtl/rrx_fault_seq.sv
module rrx_fault_seq
  import rrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fault_valid,
  input  logic resume,
  output logic take_o,
  output logic hold_o
);

  ctl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    take_o  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (fault_valid) begin
          take_o  = 1'b1;
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (resume) begin
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  assign hold_o = (state_q == ST_HOLD);

endmodule

// File: rtl/rrx_redirect_reg.sv
module rrx_redirect_reg
  import rrx_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              in_region,
  input  logic [PC_W-1:0]   head_pc,
  input  logic [PC_W-1:0]   fault_pc,
  output logic              flush_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [SAVE_W-1:0] mask_o
);

  logic              flush_q;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [SAVE_W-1:0] mask_q, mask_d;

  always_comb begin
    pc_d   = in_region ? head_pc : fault_pc;
    mask_d = save_classes(in_region);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      pc_q    <= '0;
      mask_q  <= '0;
    end else begin
      flush_q <= take;
      if (take) begin
        pc_q   <= pc_d;
        mask_q <= mask_d;
      end
    end
  end

  assign flush_o = flush_q;
  assign pc_o    = pc_q;
  assign mask_o  = mask_q;

endmodule

// File: rtl/restart_region_ctrl.sv
module restart_region_ctrl
  import rrx_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic [PC_W-1:0]   ret_pc,
  input  logic              ret_begin,
  input  logic              ret_end,
  input  logic              fault_valid,
  input  logic [PC_W-1:0]   fault_pc,
  input  logic              resume,
  output logic              flush_o,
  output logic [PC_W-1:0]   redirect_pc_o,
  output logic [SAVE_W-1:0] save_mask_o,
  output logic              halted_o,
  output logic              region_open_o,
  output logic [PC_W-1:0]   head_pc_o
);

  logic take;
  logic hold;
  logic accept;

  // A fault in the same cycle discards the retire; frozen state discards all.
  assign accept = ret_valid && !hold && !fault_valid;

  rrx_fault_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_valid (fault_valid),
    .resume      (resume),
    .take_o      (take),
    .hold_o      (hold)
  );

  rrx_region_track #(
    .PC_W        (PC_W),
    .INSTR_BYTES (INSTR_BYTES)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .is_begin (ret_begin),
    .is_end   (ret_end),
    .pc       (ret_pc),
    .open_o   (region_open_o),
    .head_o   (head_pc_o)
  );

  rrx_redirect_reg #(
    .PC_W (PC_W)
  ) u_redir (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .in_region (region_open_o),
    .head_pc   (head_pc_o),
    .fault_pc  (fault_pc),
    .flush_o   (flush_o),
    .pc_o      (redirect_pc_o),
    .mask_o    (save_mask_o)
  );

  assign halted_o = hold;

endmodule

// File: rtl/rrx_checker.sv
module rrx_checker #(
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ret_valid,
  input logic [PC_W-1:0] ret_pc,
  input logic            ret_begin,
  input logic            ret_end,
  input logic            fault_valid,
  input logic [PC_W-1:0] fault_pc,
  input logic            resume,
  input logic            flush_o,
  input logic [PC_W-1:0] redirect_pc_o,
  input logic [2:0]      save_mask_o,
  input logic            halted_o,
  input logic            region_open_o,
  input logic [PC_W-1:0] head_pc_o
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  a_r2_begin_loads_head: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_begin && !fault_valid && !halted_o)
      |=> (region_open_o && head_pc_o == $past(ret_pc) + STEP));

  a_r4_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_end && !ret_begin && !fault_valid && !halted_o)
      |=> (!region_open_o && $stable(head_pc_o)));

  a_r5_region_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !halted_o && region_open_o)
      |=> (flush_o && redirect_pc_o == $past(head_pc_o) && save_mask_o == 3'b011));

  a_r6_precise_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !halted_o && !region_open_o)
      |=> (flush_o && redirect_pc_o == $past(fault_pc) && save_mask_o == 3'b101));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);

  a_r7_pulse_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_o) |-> halted_o);

  a_r8_frozen_state: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> ($stable(head_pc_o) && $stable(region_open_o) && !flush_o));

  a_r8_resume_release: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && resume) |=> !halted_o);

  a_r9_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !halted_o) |=> ($stable(head_pc_o) && $stable(region_open_o) && halted_o));

endmodule

bind restart_region_ctrl rrx_checker #(
  .PC_W        (PC_W),
  .INSTR_BYTES (INSTR_BYTES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ret_valid     (ret_valid),
  .ret_pc        (ret_pc),
  .ret_begin     (ret_begin),
  .ret_end       (ret_end),
  .fault_valid   (fault_valid),
  .fault_pc      (fault_pc),
  .resume        (resume),
  .flush_o       (flush_o),
  .redirect_pc_o (redirect_pc_o),
  .save_mask_o   (save_mask_o),
  .halted_o      (halted_o),
  .region_open_o (region_open_o),
  .head_pc_o     (head_pc_o)
);

// File: tb/sim_restart_region_ctrl.sv
`timescale 1ns/1ps
module sim_restart_region_ctrl;

  localparam int PW = 16;
  localparam int IB = 2;

  typedef struct packed {
    logic [PW-1:0] pc;
    logic [2:0]    mask;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ret_valid, ret_begin, ret_end, fault_valid, resume;
  logic [PW-1:0] ret_pc, fault_pc;
  logic          flush_o, halted_o, region_open_o;
  logic [PW-1:0] redirect_pc_o, head_pc_o;
  logic [2:0]    save_mask_o;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  restart_region_ctrl #(.PC_W(PW), .INSTR_BYTES(IB)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_begin(ret_begin), .ret_end(ret_end),
    .fault_valid(fault_valid), .fault_pc(fault_pc), .resume(resume),
    .flush_o(flush_o), .redirect_pc_o(redirect_pc_o), .save_mask_o(save_mask_o),
    .halted_o(halted_o), .region_open_o(region_open_o), .head_pc_o(head_pc_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every flush must match the oldest queued expectation.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done && flush_o === 1'b1) begin
      if (sb_q.size() == 0) begin
        chk("R7/R8 unexpected flush", 32'(flush_o), 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R5/R6 redirect pc", 32'(redirect_pc_o), 32'(e.pc));
        chk("R5/R6 save mask", 32'(save_mask_o), 32'(e.mask));
      end
    end
  end

  task automatic idle();
    ret_valid = 0; ret_begin = 0; ret_end = 0; ret_pc = '0;
    fault_valid = 0; fault_pc = '0; resume = 0;
  endtask

  task automatic retire(input logic [PW-1:0] pc, input logic b, input logic e);
    @(negedge clk);
    idle();
    ret_valid = 1; ret_pc = pc; ret_begin = b; ret_end = e;
    @(negedge clk);
    idle();
  endtask

  // Driver: fault (optionally with a colliding retire), expectation pushed if taken.
  task automatic fault(input logic [PW-1:0] pc, input logic take,
                       input logic [PW-1:0] exp_pc, input logic [2:0] exp_mask,
                       input logic rb, input logic re);
    exp_t e;
    @(negedge clk);
    idle();
    fault_valid = 1; fault_pc = pc;
    if (rb || re) begin
      ret_valid = 1; ret_pc = pc + 16'h40; ret_begin = rb; ret_end = re;
    end
    if (take) begin
      e.pc = exp_pc; e.mask = exp_mask;
      sb_q.push_back(e);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic do_resume();
    @(negedge clk);
    idle();
    resume = 1;
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 region flag", 32'(region_open_o), 32'd0);
    chk("R1 head", 32'(head_pc_o), 32'd0);
    chk("R1 flush", 32'(flush_o), 32'd0);
    chk("R1 halted", 32'(halted_o), 32'd0);

    // R8: resume while running does nothing
    do_resume();
    chk("R8 resume while running", 32'(halted_o), 32'd0);

    // R6: fault outside any region
    fault(16'h0100, 1, 16'h0100, 3'b101, 0, 0);
    chk("R8 halted after fault", 32'(halted_o), 32'd1);
    // R8: begin and fault while frozen are ignored
    retire(16'h0500, 1, 0);
    chk("R8 begin ignored flag", 32'(region_open_o), 32'd0);
    chk("R8 begin ignored head", 32'(head_pc_o), 32'd0);
    fault(16'h0600, 0, 16'h0, 3'b0, 0, 0);
    chk("R8 still halted", 32'(halted_o), 32'd1);
    do_resume();
    chk("R8 resume clears", 32'(halted_o), 32'd0);

    // R2: open a region
    retire(16'h0200, 1, 0);
    chk("R2 open", 32'(region_open_o), 32'd1);
    chk("R2 head", 32'(head_pc_o), 32'h0202);
    retire(16'h0202, 0, 0);
    retire(16'h0204, 0, 0);
    chk("R2 plain retire keeps head", 32'(head_pc_o), 32'h0202);
    // R5: fault inside region
    fault(16'h020A, 1, 16'h0202, 3'b011, 0, 0);
    do_resume();

    // R3: second begin overwrites
    retire(16'h0300, 1, 0);
    chk("R3 overwrite head", 32'(head_pc_o), 32'h0302);
    chk("R3 still open", 32'(region_open_o), 32'd1);
    // R4: end closes, head kept
    retire(16'h0310, 0, 1);
    chk("R4 closed", 32'(region_open_o), 32'd0);
    chk("R4 head kept", 32'(head_pc_o), 32'h0302);
    fault(16'h0320, 1, 16'h0320, 3'b101, 0, 0);
    do_resume();

    // R9: fault and begin together
    retire(16'h0400, 1, 0);
    fault(16'h0410, 1, 16'h0402, 3'b011, 1, 0);
    chk("R9 head untouched", 32'(head_pc_o), 32'h0402);
    do_resume();
    // R9: fault and end together, region stays open
    fault(16'h0420, 1, 16'h0402, 3'b011, 0, 1);
    chk("R9 end discarded", 32'(region_open_o), 32'd1);
    do_resume();

    // R4: both flags set -> begin wins
    retire(16'h0700, 1, 1);
    chk("R4 both flags open", 32'(region_open_o), 32'd1);
    chk("R4 both flags head", 32'(head_pc_o), 32'h0702);

    // R2: wrap at top of address space
    retire(16'hFFFE, 1, 0);
    chk("R2 wrap head", 32'(head_pc_o), 32'h0000);
    fault(16'h0004, 1, 16'h0000, 3'b011, 0, 0);
    do_resume();

    repeat (3) @(negedge clk);
    chk("R7 all flushes seen", 32'(sb_q.size()), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule